// File: doc/BRIEF.md
# Streaming Integer Multiplier

This block multiplies two integer operands and returns the low half of their product. Both sides use a valid/ready handshake: a word moves across an interface on a rising clock edge only when valid and ready are both high in that cycle. Otherwise the sender holds the word and offers it again in the next cycle. Because of this handshake, whatever feeds the block and whatever consumes its result work correctly for any latency and under any back-pressure.

The input word packs both operands. A single stage of registers captures them together with a flag that marks the stage as full. The product is formed by combinational logic driven from those registers. While the consumer stalls, the stage keeps its result. When the held result is taken, the stage can take a new operand pair in that same cycle, so an unstalled stream moves one product per clock.

Top module: `stream_mul`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, leaves `outValid` low, `inReady` high and `outMsg` zero after that edge.
- R2: The operands are the upper half `inMsg[2*OPW-1:OPW]` and the lower half `inMsg[OPW-1:0]`. `outMsg` is the product of the most recently accepted pair.
- R3: When an input transfer happens on an edge, `outValid` is high after that edge and `outMsg` holds the product of that pair. With no stall, the result is visible in the cycle after acceptance.
- R4: `outMsg` is the product reduced to its low `OPW` bits (for example 0xFFFFFFFF times 2 gives 0xFFFFFFFE, and 0x10000 times 0x10000 gives 0).
- R5: While `outValid` is high and `outReady` is low, `outValid` stays high and `outMsg` stays unchanged on the next edge.
- R6: `inReady` is high exactly when `outValid` is low or `outReady` is high. It does not depend on `inValid`. `outValid` does not depend on `outReady` within a cycle.
- R7: When an output transfer and an input transfer happen on the same edge, the new pair is captured and `outValid` stays high. A stream with no stall delivers one product per cycle.
- R8: When an output transfer happens on an edge with no input transfer, `outValid` is low after that edge.
- R9: An input word offered without a transfer, either because `inValid` is low or because `inReady` is low, leaves `outMsg` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | An operand word is offered |
| inReady | output | 1 | The stage can take an operand word |
| inMsg | input | 2*OPW | Packed operands, upper half first |
| outValid | output | 1 | A product is held for the consumer |
| outReady | input | 1 | The consumer takes the product |
| outMsg | output | OPW | Low half of the product |

## Verification
The bench builds two instances at the default 32-bit operand width. One uses the operator multiplier (`MUL_STYLE` 0) and the other uses the shift-and-add multiplier (`MUL_STYLE` 1). Both are driven by the same stimulus and checked against the same expected values, so each directed case covers both product variants. At 32 bits, all-ones operands and operands that carry beyond bit 31 can be used, which lets the bench check truncation at the real word boundary.

// File: rtl/stream_mul_pkg.sv
package stream_mul_pkg;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic loadOps;   // capture a new operand pair this edge
  } mulCtrl_t;

endpackage

// File: rtl/stream_mul_ctrl.sv
module stream_mul_ctrl
  import stream_mul_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output logic     inReady,
  output logic     outValid,
  input  logic     outReady,
  output mulCtrl_t strobes
);

  logic fullQ;
  logic inFire;
  logic outFire;

  // Ready looks only at occupancy and downstream ready, never at inValid
  assign inReady  = !fullQ || outReady;
  assign outValid = fullQ;

  assign inFire  = inValid && inReady;
  assign outFire = fullQ && outReady;

  always_comb begin
    strobes = '0;
    strobes.loadOps = inFire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fullQ <= 1'b0;
    end else if (inFire) begin
      fullQ <= 1'b1;
    end else if (outFire) begin
      fullQ <= 1'b0;
    end
  end

endmodule

// File: rtl/stream_mul_dpath.sv
module stream_mul_dpath
  import stream_mul_pkg::*;
#(
  parameter int OPW       = 32,
  parameter int MUL_STYLE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  mulCtrl_t         strobes,
  input  logic [2*OPW-1:0] inMsg,
  output logic [OPW-1:0]   outMsg
);

  localparam int MSGW = 2 * OPW;

  logic [OPW-1:0] opA;
  logic [OPW-1:0] opB;
  logic [OPW-1:0] prodLow;

  always_ff @(posedge clk) begin
    if (rst) begin
      opA <= '0;
      opB <= '0;
    end else if (strobes.loadOps) begin
      opA <= inMsg[MSGW-1:OPW];
      opB <= inMsg[OPW-1:0];
    end
  end

  generate
    if (MUL_STYLE == 0) begin : g_opMul
      assign prodLow = opA * opB;
    end else begin : g_shiftAdd
      always_comb begin
        logic [OPW-1:0] acc;
        acc = '0;
        for (int i = 0; i < OPW; i++) begin
          if (opB[i]) begin
            acc = acc + (opA << i);
          end
        end
        prodLow = acc;
      end
    end
  endgenerate

  assign outMsg = prodLow;

endmodule

// File: rtl/stream_mul.sv
module stream_mul
  import stream_mul_pkg::*;
#(
  parameter int OPW       = 32,
  parameter int MUL_STYLE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [2*OPW-1:0] inMsg,
  output logic             outValid,
  input  logic             outReady,
  output logic [OPW-1:0]   outMsg
);

  mulCtrl_t strobes;

  stream_mul_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobes  (strobes)
  );

  stream_mul_dpath #(
    .OPW       (OPW),
    .MUL_STYLE (MUL_STYLE)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inMsg   (inMsg),
    .outMsg  (outMsg)
  );

endmodule

// File: rtl/stream_mul_chk.sv
module stream_mul_chk #(
  parameter int OPW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic [2*OPW-1:0] inMsg,
  input logic             outValid,
  input logic             outReady,
  input logic [OPW-1:0]   outMsg
);

  logic           rstD;
  logic [OPW-1:0] expNow;

  assign expNow = inMsg[2*OPW-1:OPW] * inMsg[OPW-1:0];

  always_ff @(posedge clk) begin
    rstD <= rst;
    if (rstD) begin
      // R1
      reset_empty_chk: assert (!outValid && outMsg == '0);
    end
  end

  // R2 R3 R4
  accept_product_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (outValid && outMsg == $past(expNow)));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outMsg)));

  // R6
  ready_rule_chk: assert property (@(posedge clk) disable iff (rst)
    inReady == (!outValid || outReady));

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !(inValid && inReady)) |=> !outValid);

  // R9
  no_xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(inValid && inReady) |=> $stable(outMsg));

endmodule

bind stream_mul stream_mul_chk #(.OPW(OPW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .inMsg    (inMsg),
  .outValid (outValid),
  .outReady (outReady),
  .outMsg   (outMsg)
);

// File: tb/test_stream_mul.sv
`timescale 1ns/1ps
module test_stream_mul;

  localparam int OPW = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [2*OPW-1:0] inMsg = '0;
  logic             outReady = 1'b0;
  logic             inReadyA, inReadyB;
  logic             outValidA, outValidB;
  logic [OPW-1:0]   outMsgA, outMsgB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stream_mul #(.OPW(OPW), .MUL_STYLE(0)) i_stream_mul (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReadyA), .inMsg(inMsg),
    .outValid(outValidA), .outReady(outReady), .outMsg(outMsgA));

  stream_mul #(.OPW(OPW), .MUL_STYLE(1)) i_stream_mul_sa (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReadyB), .inMsg(inMsg),
    .outValid(outValidB), .outReady(outReady), .outMsg(outMsgB));

  function automatic logic [OPW-1:0] lowProd(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    logic [2*OPW-1:0] full;
    full = {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
    return full[OPW-1:0];
  endfunction

  task automatic check(input string tag, input logic [OPW-1:0] act, input logic [OPW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Checks valid, ready and product on both variants
  task automatic checkState(input string tag, input logic expValid, input logic expReady,
                            input logic [OPW-1:0] expMsg);
    check({tag, " outValid"}, {31'b0, outValidA}, {31'b0, expValid});
    check({tag, " outValid sa"}, {31'b0, outValidB}, {31'b0, expValid});
    check({tag, " inReady"}, {31'b0, inReadyA}, {31'b0, expReady});
    check({tag, " inReady sa"}, {31'b0, inReadyB}, {31'b0, expReady});
    check({tag, " outMsg"}, outMsgA, expMsg);
    check({tag, " outMsg sa"}, outMsgB, expMsg);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                       input logic rdy);
    inValid  = v;
    inMsg    = {a, b};
    outReady = rdy;
    #1;
  endtask

  task automatic testReset();
    tick();
    rst = 1'b0;
    #1;
    checkState("R1 after reset", 1'b0, 1'b1, '0);
  endtask

  task automatic testBasic();
    drive(1'b1, 32'd2, 32'd3, 1'b1);
    checkState("R6 empty ready", 1'b0, 1'b1, '0);
    tick();
    drive(1'b0, '0, '0, 1'b1);
    checkState("R3 R2 2x3", 1'b1, 1'b1, 32'd6);
    tick();
    checkState("R8 drained", 1'b0, 1'b1, 32'd6);
  endtask

  task automatic testHalves();
    drive(1'b1, 32'd1, 32'd0, 1'b1);
    tick();
    drive(1'b1, 32'd0, 32'd5, 1'b1);
    checkState("R2 upper one lower zero", 1'b1, 1'b1, 32'd0);
    tick();
    drive(1'b1, 32'd7, 32'h100, 1'b1);
    checkState("R2 upper zero lower five", 1'b1, 1'b1, 32'd0);
    tick();
    drive(1'b0, '0, '0, 1'b1);
    checkState("R2 7x0x100", 1'b1, 1'b1, lowProd(32'd7, 32'h100));
    tick();
  endtask

  task automatic testTruncate();
    drive(1'b1, 32'hFFFF_FFFF, 32'd2, 1'b1);
    tick();
    drive(1'b1, 32'h0001_0000, 32'h0001_0000, 1'b1);
    checkState("R4 allones x2", 1'b1, 1'b1, 32'hFFFF_FFFE);
    tick();
    drive(1'b1, 32'h10, 32'h2, 1'b1);
    checkState("R4 carry out", 1'b1, 1'b1, 32'h0);
    tick();
    drive(1'b0, '0, '0, 1'b1);
    checkState("R4 0x10x2", 1'b1, 1'b1, 32'h20);
    tick();
  endtask

  task automatic testBackpressure();
    drive(1'b1, 32'd4, 32'd5, 1'b0);
    tick();
    drive(1'b0, 32'd9, 32'd9, 1'b0);
    checkState("R6 full stalled idle", 1'b1, 1'b0, 32'd20);
    inValid = 1'b1;
    #1;
    checkState("R6 full stalled offered", 1'b1, 1'b0, 32'd20);
    for (int k = 0; k < 3; k++) begin
      tick();
      checkState("R5 R9 held under stall", 1'b1, 1'b0, 32'd20);
    end
    outReady = 1'b1;
    #1;
    checkState("R6 ready follows consumer", 1'b1, 1'b1, 32'd20);
    tick();
    drive(1'b0, '0, '0, 1'b1);
    checkState("R7 swap on same edge", 1'b1, 1'b1, 32'd81);
    tick();
    checkState("R8 empty after drain", 1'b0, 1'b1, 32'd81);
  endtask

  task automatic testStream();
    for (int i = 1; i <= 6; i++) begin
      drive(1'b1, 32'(i), 32'(i + 3), 1'b1);
      tick();
      checkState("R7 back to back", 1'b1, 1'b1, lowProd(32'(i), 32'(i + 3)));
    end
    drive(1'b0, '0, '0, 1'b1);
    tick();
    checkState("R8 stream end", 1'b0, 1'b1, lowProd(32'd6, 32'd9));
  endtask

  task automatic testIdle();
    drive(1'b0, 32'd11, 32'd13, 1'b0);
    tick();
    tick();
    checkState("R9 idle word ignored", 1'b0, 1'b1, lowProd(32'd6, 32'd9));
  endtask

  task automatic testMidReset();
    drive(1'b1, 32'd3, 32'd3, 1'b0);
    tick();
    drive(1'b0, '0, '0, 1'b0);
    checkState("R5 full before reset", 1'b1, 1'b0, 32'd9);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    #1;
    checkState("R1 reset while full", 1'b0, 1'b1, '0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testBasic();
    testHalves();
    testTruncate();
    testBackpressure();
    testStream();
    testIdle();
    testMidReset();
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule